// File: doc/BRIEF.md
# Prescaled Up-Counter Timer

This block is an up-counter that counts input ticks and runs either as an 8-bit timer or as a 16-bit timer. Ahead of it sits a hidden 8-bit prescaler. When the prescaler is in use, the timer advances once every 2, 4, 8 and so on up to 256 ticks. When the prescaler is bypassed, the timer advances on every tick. Each wrap of the active width sets a sticky overflow flag. The interrupt request output is that flag gated by an enable bit.

Software reaches the block through a byte-wide register port with four addresses: count low byte, count high byte, control and flags. Every write carries a per-bit mask, so a single-bit write is an ordinary write with one mask bit set. A write to either count byte always empties the prescaler, even when the mask is zero, and it leaves the control settings alone. The ratio and the bypass setting can be changed while the timer runs. A sleep input freezes both the prescaler and the timer.

Top module: `prescaled_timer`

## Requirements
- R1: After a synchronous reset, all four registers read 0 and `irq` is 0.
- R2: With control bit 2 (bypass) at 0, the 3-bit select field in control bits 5:3 sets the ratio to 2^(code+1) ticks per timer step, counted from the last prescaler clear. Code 000 gives 1:2 and code 111 gives 1:256.
- R3: With bypass at 1, the timer steps on every tick.
- R4: Any write strobe to address 0 (count low) or address 1 (count high) clears the prescaler, whatever the data and mask. The control register keeps its value.
- R5: With control bit 1 (wide) at 0, only the low byte counts and it wraps 0xFF to 0x00 while the high byte holds. With wide at 1, the full 16-bit count wraps 0xFFFF to 0x0000.
- R6: Each wrap sets the flag (flags bit 0). `irq` is high exactly when the flag and the enable (flags bit 1) are both 1.
- R7: The flag stays set until software writes 0 to flags bit 0. An overflow in the same cycle as that clearing write leaves the flag set.
- R8: While `sleep_in` is 1, neither the prescaler nor the timer advances, so no overflow can occur.
- R9: While the run bit (control bit 0) is 0, both the prescaler and the timer hold.
- R10: A count write takes priority over a same-cycle step and changes only the bits its mask selects. An overflow in that same cycle still sets the flag.
- R11: A change of ratio or bypass made while the timer runs applies from the next tick, starting from the current prescaler count, with no reset.
- R12: Reads are combinational: address 0 gives count low, 1 gives count high, 2 gives control (bits 7:6 always read 0), and 3 gives {0, enable, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Count event, one per cycle at most |
| sleep_in | input | 1 | Freezes all counting while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| wr_mask | input | DW | Per-bit write enable |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A write, or the tick that completes a prescaler period, is applied at the next rising edge. The effect therefore shows on `rd_data` one edge after the stimulus, and an overflow reaches the flag and `irq` at that same edge. Register reads are combinational and add no delay. The bench drives inputs on the falling edge, waits for the rising edge plus 1 ns, then moves `rd_addr` and samples after a short settle. Every expected value is therefore taken exactly one edge after the cycle that caused it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_FLAGS  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic [SEL_W-1:0] sel;
        logic             bypass;
        logic             wide;
        logic             run;
    } ctrl_t;

    localparam logic [7:0] CTRL_WMASK = 8'h3F;

    // low-order prescaler bits that must all be 1 to finish a period
    function automatic logic [31:0] ratio_mask(input logic [SEL_W-1:0] sel);
        return (32'd2 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic [PRE_W-1:0] pre_q;
    logic [31:0]      full_mask;
    logic [PRE_W-1:0] mask;

    assign full_mask = ratio_mask(sel);
    assign mask      = full_mask[PRE_W-1:0];
    assign pulse     = advance && (&(pre_q | ~mask));

    always_ff @(posedge clk) begin
        if (rst || clear)  pre_q <= '0;
        else if (advance)  pre_q <= pre_q + PRE_W'(1);
    end

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> pre_q == '0); // R4
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(pre_q)); // R9

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            wide,
    input  logic [1:0]      wr_lane,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   wr_mask,
    output logic [2*DW-1:0] count,
    output logic            ovf
);
    localparam int NB = 2;
    localparam int CW = NB * DW;

    logic [CW-1:0] count_q;
    logic [CW-1:0] bumped;
    logic          any_wr;

    assign any_wr = |wr_lane;
    assign bumped = wide ? count_q + CW'(1)
                         : {count_q[CW-1:DW], count_q[DW-1:0] + DW'(1)};
    assign ovf    = inc && (wide ? (&count_q) : (&count_q[DW-1:0]));
    assign count  = count_q;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                count_q[g*DW +: DW] <= '0;
            else if (any_wr) begin
                if (wr_lane[g])
                    count_q[g*DW +: DW] <= (count_q[g*DW +: DW] & ~wr_mask)
                                         | (wr_data & wr_mask);
            end else if (inc)
                count_q[g*DW +: DW] <= bumped[g*DW +: DW];
        end
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !any_wr) |=> $stable(count_q)); // R9
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ovf && !any_wr) |=> count_q[DW-1:0] == '0); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_lane[0] && (&wr_mask)) |=> count_q[DW-1:0] == $past(wr_data)); // R10

endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovf,
    input  logic       sw_wr,
    input  logic [1:0] sw_data,
    input  logic [1:0] sw_mask,
    output logic       flag,
    output logic       ie,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (ovf)                        flag <= 1'b1;
            else if (sw_wr && sw_mask[0])   flag <= sw_data[0];
            if (sw_wr && sw_mask[1])        ie   <= sw_data[1];
        end
    end

    assign irq = flag && ie;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !(sw_wr && sw_mask[0] && !sw_data[0])) |=> flag); // R7

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PRE_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_in,
    input  logic          sleep_in,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] wr_mask,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int CW = 2 * DW;

    ctrl_t         ctrl_q;
    logic          live_tick;
    logic          pre_pulse;
    logic          inc;
    logic [1:0]    cnt_wr;
    logic          flags_wr;
    logic [CW-1:0] count;
    logic          ovf;
    logic          flag;
    logic          ie;
    reg_addr_e     waddr;

    assign waddr     = reg_addr_e'(wr_addr);
    assign cnt_wr[0] = wr_en && (waddr == A_CNT_LO);
    assign cnt_wr[1] = wr_en && (waddr == A_CNT_HI);
    assign flags_wr  = wr_en && (waddr == A_FLAGS);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && waddr == A_CTRL)
            ctrl_q <= (ctrl_q & ~(wr_mask[7:0] & CTRL_WMASK))
                    | (wr_data[7:0] & wr_mask[7:0] & CTRL_WMASK);
    end

    assign live_tick = tick_in && ctrl_q.run && !sleep_in;

    ptmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .advance (live_tick && !ctrl_q.bypass),
        .clear   (|cnt_wr),
        .sel     (ctrl_q.sel),
        .pulse   (pre_pulse)
    );

    assign inc = ctrl_q.bypass ? live_tick : pre_pulse;

    ptmr_counter #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .wide    (ctrl_q.wide),
        .wr_lane (cnt_wr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .count   (count),
        .ovf     (ovf)
    );

    ptmr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .ovf     (ovf),
        .sw_wr   (flags_wr),
        .sw_data (wr_data[1:0]),
        .sw_mask (wr_mask[1:0]),
        .flag    (flag),
        .ie      (ie),
        .irq     (irq)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_CNT_LO: rd_data = count[DW-1:0];
            A_CNT_HI: rd_data = count[CW-1:DW];
            A_CTRL:   rd_data = DW'(ctrl_q);
            default:  rd_data = DW'({ie, flag});
        endcase
    end

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sleep_in && !(|cnt_wr)) |=> $stable(count)); // R8
    AST_SLEEP_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        sleep_in |-> !ovf); // R8

endmodule

// File: tb/prescaled_timer_test.sv
`timescale 1ns/100ps
module prescaled_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       sleep_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] wr_mask = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;

    prescaled_timer uut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .sleep_in(sleep_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // rows: [31] bypass, [30:28] select, [27:16] ticks, [15:0] expected count
    localparam logic [31:0] VEC [6] = '{
        {1'b0, 3'd0, 12'd10,  16'd5},
        {1'b0, 3'd1, 12'd10,  16'd2},
        {1'b0, 3'd2, 12'd17,  16'd2},
        {1'b0, 3'd3, 12'd40,  16'd2},
        {1'b0, 3'd7, 12'd600, 16'd2},
        {1'b1, 3'd0, 12'd7,   16'd7}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (cyc_n > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc_n);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        tick_in = t; wr_en = w; wr_addr = a; wr_data = d; wr_mask = m;
        @(posedge clk);
        #1;
        tick_in = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d, 8'hFF);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    logic [7:0] lo, hi, v;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;

        // R1 / R12 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", "reset register", {24'd0, v}, 32'h0);
        end
        chk("R1", "reset irq", {31'd0, irq}, 32'd0);

        // R2 / R3 ratio table, 16-bit mode
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, {2'b00, VEC[i][30:28], VEC[i][31], 2'b11});
            wr(2'd0, 8'h00);
            wr(2'd1, 8'h00);
            ticks(int'(VEC[i][27:16]));
            rd(2'd0, lo); rd(2'd1, hi);
            chk(VEC[i][31] ? "R3" : "R2", "table count", {16'd0, hi, lo},
                {16'd0, VEC[i][15:0]});
        end

        // R12 control readback: reserved bits read 0
        wr(2'd2, 8'hFF);
        rd(2'd2, v);
        chk("R12", "ctrl reserved bits", {24'd0, v}, 32'h3F);

        // R5 8-bit wrap, high byte holds
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h12);
        wr(2'd0, 8'hFE);
        ticks(2);
        rd(2'd0, lo); rd(2'd1, hi);
        chk("R5", "8-bit wrap low", {24'd0, lo}, 32'h00);
        chk("R5", "8-bit wrap high held", {24'd0, hi}, 32'h12);
        rd(2'd3, v);
        chk("R6", "flag set, masked", {23'd0, irq, v}, {23'd0, 1'b0, 8'h01});
        cyc(1'b0, 1'b1, 2'd3, 8'h03, 8'h02);
        chk("R6", "irq after enable", {31'd0, irq}, 32'd1);
        ticks(3);
        rd(2'd3, v);
        chk("R7", "flag sticky", {24'd0, v}, 32'h03);
        cyc(1'b0, 1'b1, 2'd3, 8'h02, 8'h01);
        rd(2'd3, v);
        chk("R7", "flag cleared by write", {23'd0, irq, v}, {23'd0, 1'b0, 8'h02});

        // R5 16-bit wrap
        wr(2'd2, 8'h07);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        ticks(1);
        rd(2'd0, lo); rd(2'd1, hi);
        chk("R5", "16-bit wrap", {16'd0, hi, lo}, 32'h0);
        chk("R6", "irq on 16-bit wrap", {31'd0, irq}, 32'd1);
        cyc(1'b0, 1'b1, 2'd3, 8'h00, 8'h01);

        // R7 overflow beats a same-cycle clear
        wr(2'd2, 8'h05);
        wr(2'd0, 8'hFF);
        cyc(1'b1, 1'b1, 2'd3, 8'h00, 8'h01);
        rd(2'd3, v);
        chk("R7", "set wins over clear", {24'd0, v}, 32'h03);
        cyc(1'b0, 1'b1, 2'd3, 8'h00, 8'h01);

        // R10 write priority, masking, coincident overflow
        wr(2'd0, 8'h10);
        cyc(1'b1, 1'b1, 2'd0, 8'h40, 8'hFF);
        rd(2'd0, lo);
        chk("R10", "write beats step", {24'd0, lo}, 32'h40);
        cyc(1'b0, 1'b1, 2'd0, 8'hFF, 8'h0F);
        rd(2'd0, lo);
        chk("R10", "masked write", {24'd0, lo}, 32'h4F);
        wr(2'd0, 8'hFF);
        cyc(1'b1, 1'b1, 2'd0, 8'h05, 8'hFF);
        rd(2'd0, lo); rd(2'd3, v);
        chk("R10", "write during overflow value", {24'd0, lo}, 32'h05);
        chk("R10", "write during overflow flag", {24'd0, v}, 32'h03);
        cyc(1'b0, 1'b1, 2'd3, 8'h00, 8'h03);

        // R8 sleep freezes timer (bypass) and prescaler
        wr(2'd0, 8'h20);
        sleep_in = 1'b1;
        ticks(5);
        rd(2'd0, lo);
        chk("R8", "sleep holds timer", {24'd0, lo}, 32'h20);
        sleep_in = 1'b0;
        ticks(1);
        rd(2'd0, lo);
        chk("R8", "wake resumes", {24'd0, lo}, 32'h21);
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h00);
        ticks(3);
        sleep_in = 1'b1;
        ticks(5);
        sleep_in = 1'b0;
        rd(2'd0, lo);
        chk("R8", "sleep holds prescaler", {24'd0, lo}, 32'h00);
        ticks(1);
        rd(2'd0, lo);
        chk("R8", "prescaler resumes", {24'd0, lo}, 32'h01);

        // R9 run bit off holds prescaler and timer
        wr(2'd0, 8'h00);
        ticks(3);
        wr(2'd2, 8'h08);
        ticks(5);
        rd(2'd0, lo);
        chk("R9", "stopped timer", {24'd0, lo}, 32'h00);
        wr(2'd2, 8'h09);
        ticks(1);
        rd(2'd0, lo);
        chk("R9", "prescaler kept count", {24'd0, lo}, 32'h01);
        wr(2'd2, 8'h04);
        ticks(3);
        rd(2'd0, lo);
        chk("R9", "stopped bypass timer", {24'd0, lo}, 32'h01);

        // R4 zero-mask count write still clears prescaler
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h00);
        rd(2'd1, hi);
        ticks(3);
        cyc(1'b0, 1'b1, 2'd1, 8'hAA, 8'h00);
        rd(2'd1, v);
        chk("R4", "zero-mask write leaves high", {24'd0, v}, {24'd0, hi});
        ticks(3);
        rd(2'd0, lo);
        chk("R4", "prescaler cleared", {24'd0, lo}, 32'h00);
        ticks(1);
        rd(2'd0, lo);
        chk("R4", "full period after clear", {24'd0, lo}, 32'h01);
        rd(2'd2, v);
        chk("R4", "control unchanged", {24'd0, v}, 32'h09);

        // R11 run-time ratio and bypass change
        wr(2'd2, 8'h11);
        wr(2'd0, 8'h00);
        ticks(3);
        wr(2'd2, 8'h01);
        ticks(1);
        rd(2'd0, lo);
        chk("R11", "ratio change uses current count", {24'd0, lo}, 32'h01);
        wr(2'd2, 8'h05);
        ticks(2);
        rd(2'd0, lo);
        chk("R11", "bypass switched on the fly", {24'd0, lo}, 32'h03);

        summary();
        $finish;
    end
endmodule